// File: doc/BRIEF.md
# Fractional-N Reference Delay Code Generator

This block is the digital controller of a fractional-N synthesizer that pairs an integer divider with a digital-to-time converter (DTC). On every rising reference edge it makes three decisions at once. It picks the integer division ratio from a first- or second-order delta-sigma modulator driven by the fractional control word. It keeps a running phase error, which is the accumulated difference between the requested ratio and the ratio actually applied. It scales that error into a DTC delay code, clamps the code to its range, and corrects it through a small writable table that pre-distorts the code against the converter's nonlinearity.

The ratio and the delay code for a given reference cycle leave the block from the same register stage, so the divider and the delay line always act on a matched pair. A zero fractional word turns the block into a plain integer-N controller with a fixed code. The delay line, the oscillator, the phase detector and the loop filter are outside this block.

Top module: `frac_ref_dtc_ctrl`

## Requirements
- R1: While `rst_n` is low, `div_ratio` and `dtc_code` are 0, the modulator and phase state are cleared, and every correction table entry is 0.
- R2: With `dsm_order2`=0 the ratio offset is the carry out of a 12-bit fraction accumulator, so `div_ratio` is `fcw_int` or `fcw_int`+1. Over 4096 cycles from reset with a constant fraction F, the offsets sum to exactly F.
- R3: With `dsm_order2`=1 the modulator is a cascade of two 12-bit accumulators, and offset = c1 + c2 − (c2 of the previous cycle). `div_ratio` stays within `fcw_int`−1 to `fcw_int`+2.
- R4: The phase error is updated every cycle by adding `fcw_frac` and subtracting offset·4096, modulo 2^15 in two's complement. Its value always lies in [−4096, 4096).
- R5: The raw code is floor(phase·`dtc_gain` / 4096) + 512, computed from the updated phase of the same cycle.
- R6: A raw code below 0 becomes 0 and one above 1023 becomes 1023.
- R7: The output code is the clamped code plus the signed 8-bit table entry addressed by clamped code bits [9:6], clamped again to 0..1023. A write with `tbl_we`=1 stores `tbl_wdata` at `tbl_addr` on the clock edge, and the code computed on that same edge still uses the old entry.
- R8: `div_ratio` and `dtc_code` both update on each rising edge of `clk_ref`, from the inputs sampled at that edge. Each ratio is paired with the code of its own cycle.
- R9: With `dsm_order2`=0, `fcw_frac`=0, and gain and table held, `div_ratio` equals `fcw_int` and `dtc_code` stays constant from the second such cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; one update per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dsm_order2 | input | 1 | 0 selects the first-order modulator, 1 selects the second-order cascade |
| fcw_int | input | 6 | Integer part of the frequency control word (kept at 1 or above) |
| fcw_frac | input | 12 | Fractional part of the control word, in units of 1/4096 |
| dtc_gain | input | 12 | Delay LSBs per output period, in units of 1/4096 of a period |
| tbl_we | input | 1 | Correction table write strobe |
| tbl_addr | input | 4 | Correction table entry to write |
| tbl_wdata | input | 8 | Two's-complement correction offset |
| div_ratio | output | 8 | Integer divider ratio for this reference cycle |
| dtc_code | output | 10 | Corrected delay code for this reference cycle |

## Verification
Four properties are checked on every cycle. The phase error stays inside its bound. The ratio stays in the window around the integer word that was applied. A table write lands in the addressed entry. With a zero fraction the code holds and the ratio equals the integer word. Exact per-cycle values cannot be shown by a local property. These include the cascade's carry sequence, the floor rounding of negative phases, clamping at both ends, table pre-distortion near the limits, and the exact average of the ratio over a full accumulator period. The bench shows these by comparing each cycle against its own model, under random control words, gains, orders and table writes.

// File: rtl/frac_ref_pkg.sv
package frac_ref_pkg;

  typedef enum logic {
    DSM_FIRST  = 1'b0,
    DSM_SECOND = 1'b1
  } dsm_order_e;

  typedef struct packed {
    logic c1;
    logic c2;
    logic c2_prev;
  } dsm_carry_t;

endpackage

// File: rtl/frac_ref_dsm.sv
module frac_ref_dsm
  import frac_ref_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dsm_order_e          order,
  input  logic [FW-1:0]       frac,
  output logic signed [2:0]   ratio_off,
  output dsm_carry_t          carries
);

  logic [FW-1:0] acc1_q, acc2_q;
  logic          c2p_q;
  logic [FW:0]   sum1, sum2;

  function automatic logic [FW:0] add_carry(input logic [FW-1:0] a, input logic [FW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic signed [2:0] combine(input logic c1, input logic c2, input logic c2p);
    return $signed({2'b00, c1}) + $signed({2'b00, c2}) - $signed({2'b00, c2p});
  endfunction

  always_comb begin
    sum1 = add_carry(acc1_q, frac);
    if (order == DSM_SECOND) sum2 = add_carry(acc2_q, sum1[FW-1:0]);
    else                     sum2 = '0;
    carries.c1      = sum1[FW];
    carries.c2      = sum2[FW];
    carries.c2_prev = c2p_q;
    ratio_off       = combine(sum1[FW], sum2[FW], c2p_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1_q <= '0;
      acc2_q <= '0;
      c2p_q  <= 1'b0;
    end else begin
      acc1_q <= sum1[FW-1:0];
      acc2_q <= sum2[FW-1:0];
      c2p_q  <= sum2[FW];
    end
  end

endmodule

// File: rtl/frac_ref_phase.sv
module frac_ref_phase #(
  parameter int FW = 12,
  parameter int PW = FW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FW-1:0]        frac,
  input  logic signed [2:0]    ratio_off,
  output logic signed [PW-1:0] ph_next,
  output logic signed [PW-1:0] ph_q
);

  localparam logic signed [PW-1:0] PH_HI = PW'(2 ** FW);
  localparam logic signed [PW-1:0] PH_LO = -PH_HI;

  function automatic logic signed [PW-1:0] phase_step(
    input logic signed [PW-1:0] ph,
    input logic [FW-1:0]        f,
    input logic signed [2:0]    off
  );
    logic signed [PW-1:0] f_ext;
    logic signed [PW-1:0] o_ext;
    f_ext = $signed({{(PW-FW){1'b0}}, f});
    o_ext = $signed({{(PW-3){off[2]}}, off}) <<< FW;
    return ph + f_ext - o_ext;
  endfunction

  always_comb ph_next = phase_step(ph_q, frac, ratio_off);

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_next;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q >= PH_LO) && (ph_q < PH_HI)); // R4

endmodule

// File: rtl/frac_ref_code_map.sv
module frac_ref_code_map #(
  parameter int FW     = 12,
  parameter int PW     = FW + 3,
  parameter int GW     = 12,
  parameter int CW     = 10,
  parameter int OW     = 8,
  parameter int TBL_AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW-1:0] ph_next,
  input  logic [GW-1:0]        gain,
  input  logic                 tbl_we,
  input  logic [TBL_AW-1:0]    tbl_addr,
  input  logic [OW-1:0]        tbl_wdata,
  output logic [CW-1:0]        code_next,
  output logic                 raw_low,
  output logic                 raw_high
);

  localparam int TBL_N = 2 ** TBL_AW;
  localparam int PRODW = PW + GW + 1;
  localparam int SUMW  = PRODW + 1;
  localparam logic signed [SUMW-1:0] BIAS     = SUMW'(2 ** (CW - 1));
  localparam logic signed [SUMW-1:0] CODE_MAX = SUMW'((2 ** CW) - 1);

  logic signed [OW-1:0]   tbl_q [TBL_N];
  logic signed [SUMW-1:0] raw_code;
  logic [CW-1:0]          clamped;
  logic [TBL_AW-1:0]      tbl_idx;
  logic signed [SUMW-1:0] corr_sum;

  function automatic logic signed [SUMW-1:0] scale_raw(
    input logic signed [PW-1:0] ph,
    input logic [GW-1:0]        g
  );
    logic signed [PRODW-1:0] ph_x, g_x, prod, shr;
    ph_x = $signed({{(PRODW-PW){ph[PW-1]}}, ph});
    g_x  = $signed({{(PRODW-GW){1'b0}}, g});
    prod = ph_x * g_x;
    shr  = prod >>> FW;
    return $signed({shr[PRODW-1], shr}) + BIAS;
  endfunction

  function automatic logic [CW-1:0] clamp_code(input logic signed [SUMW-1:0] v);
    if (v < 0)             return '0;
    else if (v > CODE_MAX) return '1;
    else                   return v[CW-1:0];
  endfunction

  always_comb begin
    raw_code  = scale_raw(ph_next, gain);
    raw_low   = raw_code < 0;
    raw_high  = raw_code > CODE_MAX;
    clamped   = clamp_code(raw_code);
    tbl_idx   = clamped[CW-1 -: TBL_AW];
    corr_sum  = $signed({{(SUMW-CW){1'b0}}, clamped})
              + $signed({{(SUMW-OW){tbl_q[tbl_idx][OW-1]}}, tbl_q[tbl_idx]});
    code_next = clamp_code(corr_sum);
  end

  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n)                                   tbl_q[i] <= '0;
      else if (tbl_we && tbl_addr == TBL_AW'(i))    tbl_q[i] <= tbl_wdata;
    end
  end

  AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> tbl_q[$past(tbl_addr)] == $signed($past(tbl_wdata))); // R7

endmodule

// File: rtl/frac_ref_dtc_ctrl.sv
module frac_ref_dtc_ctrl
  import frac_ref_pkg::*;
#(
  parameter int IW     = 6,
  parameter int FW     = 12,
  parameter int GW     = 12,
  parameter int CW     = 10,
  parameter int OW     = 8,
  parameter int TBL_AW = 4
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              dsm_order2,
  input  logic [IW-1:0]     fcw_int,
  input  logic [FW-1:0]     fcw_frac,
  input  logic [GW-1:0]     dtc_gain,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic [OW-1:0]     tbl_wdata,
  output logic [IW+1:0]     div_ratio,
  output logic [CW-1:0]     dtc_code
);

  localparam int RW = IW + 2;
  localparam int PW = FW + 3;

  dsm_order_e           order;
  logic signed [2:0]    ratio_off;
  dsm_carry_t           carries;
  logic signed [PW-1:0] ph_next, ph_q;
  logic [CW-1:0]        code_next;
  logic                 raw_low, raw_high;
  logic [RW-1:0]        ratio_next;
  logic                 seen_q;

  assign order = dsm_order2 ? DSM_SECOND : DSM_FIRST;

  function automatic logic [RW-1:0] apply_offset(input logic [IW-1:0] base, input logic signed [2:0] off);
    return {2'b00, base} + {{(RW-3){off[2]}}, off};
  endfunction

  assign ratio_next = apply_offset(fcw_int, ratio_off);

  frac_ref_dsm #(.FW(FW)) u_dsm (
    .clk(clk_ref), .rst_n(rst_n), .order(order), .frac(fcw_frac),
    .ratio_off(ratio_off), .carries(carries)
  );

  frac_ref_phase #(.FW(FW), .PW(PW)) u_phase (
    .clk(clk_ref), .rst_n(rst_n), .frac(fcw_frac), .ratio_off(ratio_off),
    .ph_next(ph_next), .ph_q(ph_q)
  );

  frac_ref_code_map #(.FW(FW), .PW(PW), .GW(GW), .CW(CW), .OW(OW), .TBL_AW(TBL_AW)) u_map (
    .clk(clk_ref), .rst_n(rst_n), .ph_next(ph_next), .gain(dtc_gain),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .code_next(code_next), .raw_low(raw_low), .raw_high(raw_high)
  );

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      div_ratio <= '0;
      dtc_code  <= '0;
      seen_q    <= 1'b0;
    end else begin
      div_ratio <= ratio_next;
      dtc_code  <= code_next;
      seen_q    <= 1'b1;
    end
  end

  AST_RATIO_WINDOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    seen_q |-> ((div_ratio + RW'(1) >= {2'b00, $past(fcw_int)}) &&
                (div_ratio <= {2'b00, $past(fcw_int)} + RW'(2)))); // R3

  AST_INTN_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seen_q && fcw_frac == '0 && !dsm_order2 && !$past(dsm_order2) &&
     $stable(dtc_gain) && !$past(tbl_we))
    |=> ($stable(dtc_code) && div_ratio == {2'b00, $past(fcw_int)})); // R9

endmodule

// File: tb/frac_ref_dtc_ctrl_tb_top.sv
module frac_ref_dtc_ctrl_tb_top;

  localparam int FW = 12;
  localparam int ONE = 2 ** FW;

  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic       dsm_order2 = 1'b0;
  logic [5:0] fcw_int = 6'd8;
  logic [11:0] fcw_frac = '0;
  logic [11:0] dtc_gain = '0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [7:0] div_ratio;
  logic [9:0] dtc_code;

  int checks = 0;
  int errors = 0;

  int m_acc1, m_acc2, m_c2p, m_ph, m_ratio, m_code;
  bit m_clip, m_lutu;
  int m_lut [16];

  always #5 clk_ref = ~clk_ref;

  frac_ref_dtc_ctrl dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .dsm_order2(dsm_order2),
    .fcw_int(fcw_int), .fcw_frac(fcw_frac), .dtc_gain(dtc_gain),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .div_ratio(div_ratio), .dtc_code(dtc_code)
  );

  function automatic int clip10(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc1 = 0; m_acc2 = 0; m_c2p = 0; m_ph = 0;
    for (int i = 0; i < 16; i++) m_lut[i] = 0;
  endtask

  task automatic model_step(bit ord2, int fi, int ff, int g, bit we, int a, int wd);
    int s1, s2, c1, c2, a1, a2, off, ph, raw, c0, idx;
    longint prod;
    s1 = m_acc1 + ff; c1 = (s1 >= ONE) ? 1 : 0; a1 = s1 % ONE;
    if (ord2) begin s2 = m_acc2 + a1; c2 = (s2 >= ONE) ? 1 : 0; a2 = s2 % ONE; end
    else begin c2 = 0; a2 = 0; end
    off = c1 + c2 - m_c2p;
    ph = (m_ph + ff - off * ONE) & 32'h7FFF;
    if (ph >= 16384) ph -= 32768;
    prod = longint'(ph) * longint'(g);
    raw = int'(prod >>> FW) + 512;
    c0 = clip10(raw);
    m_clip = (c0 != raw);
    idx = c0 / 64;
    m_lutu = (m_lut[idx] != 0);
    m_code = clip10(c0 + m_lut[idx]);
    m_ratio = fi + off;
    m_acc1 = a1; m_acc2 = a2; m_c2p = c2; m_ph = ph;
    if (we) m_lut[a] = (wd >= 128) ? wd - 256 : wd;
  endtask

  // Drive at the falling edge, the design updates at the rising edge, sample 2 ns later.
  task automatic run_cycle(bit ord2, int fi, int ff, int g, bit we, int a, int wd,
                           string rtag, string ctag);
    string tag;
    dsm_order2 = ord2; fcw_int = 6'(fi); fcw_frac = 12'(ff); dtc_gain = 12'(g);
    tbl_we = we; tbl_addr = 4'(a); tbl_wdata = 8'(wd);
    model_step(ord2, fi, ff, g, we, a, wd);
    @(posedge clk_ref); #2;
    check(rtag, int'(div_ratio), m_ratio);
    tag = m_clip ? "R6" : (m_lutu ? "R7" : ctag);
    check(tag, int'(dtc_code), m_code);
    @(negedge clk_ref);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_ref);
    rst_n = 1'b0; tbl_we = 1'b0;
    model_reset();
    repeat (3) @(negedge clk_ref);
    check("R1 ratio in reset", int'(div_ratio), 0);
    check("R1 code in reset", int'(dtc_code), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed, sum, fi, ff, g, cz, lo_seen, hi_seen, first_code;
    bit r3_range;
    seed = int'($urandom(32'd20240607));

    // R1: table cleared by reset is seen through an unclipped mid code
    do_reset();
    run_cycle(0, 8, 0, 0, 0, 0, 0, "R1 ratio", "R1");

    // R2: exact average over one accumulator period, first order
    do_reset();
    sum = 0;
    for (int k = 0; k < ONE; k++) begin
      run_cycle(0, 10, 1234, 2048, 0, 0, 0, "R2", "R4");
      sum += int'(div_ratio) - 10;
    end
    check("R2 offset sum", sum, 1234);

    // R9: integer-N, constant ratio and code
    do_reset();
    run_cycle(0, 12, 0, 3000, 0, 0, 0, "R9", "R9");
    first_code = int'(dtc_code);
    for (int k = 0; k < 40; k++) begin
      run_cycle(0, 12, 0, 3000, 0, 0, 0, "R9", "R9");
      check("R9 code held", int'(dtc_code), first_code);
    end

    // R3, R4, R5: second order, random fraction and gain
    do_reset();
    r3_range = 1'b1;
    ff = int'($urandom_range(1, ONE - 1));
    g = int'($urandom_range(1, 1024));
    for (int k = 0; k < 3000; k++) begin
      run_cycle(1, 20, ff, g, 0, 0, 0, "R3", "R5");
      if (int'(div_ratio) < 19 || int'(div_ratio) > 22) r3_range = 1'b0;
    end
    check("R3 ratio window", int'(r3_range), 1);

    // R6: large gain drives both clamps
    do_reset();
    lo_seen = 0; hi_seen = 0;
    for (int k = 0; k < 3000; k++) begin
      run_cycle(1, 16, 1597, 4095, 0, 0, 0, "R3", "R5");
      if (dtc_code == 10'd0) lo_seen = 1;
      if (dtc_code == 10'd1023) hi_seen = 1;
    end
    check("R6 low clamp seen", lo_seen, 1);
    check("R6 high clamp seen", hi_seen, 1);

    // R7: table writes, incl. extreme offsets near the range ends
    run_cycle(1, 16, 1597, 4095, 1, 15, 127, "R3", "R7");
    run_cycle(1, 16, 1597, 4095, 1, 0, 128, "R3", "R7");
    for (int k = 0; k < 16; k++)
      run_cycle(0, 16, 500, 2000, 1, k, int'($urandom_range(0, 255)), "R2", "R7");
    for (int k = 0; k < 2000; k++)
      run_cycle(bit'($urandom_range(0, 1)), 16, int'($urandom_range(0, ONE - 1)),
                int'($urandom_range(0, 4095)), bit'($urandom_range(0, 7) == 0),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), "R3", "R7");

    // R8: integer word changing every cycle stays paired with its own code
    do_reset();
    cz = 0;
    for (int k = 0; k < 2000; k++) begin
      fi = int'($urandom_range(2, 63));
      run_cycle(bit'(k / 500 % 2), fi, int'($urandom_range(0, ONE - 1)),
                int'($urandom_range(0, 4095)), 0, 0, 0, "R8", "R8");
      cz++;
    end
    check("R8 cycles run", cz, 2000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule